// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of an asynchronous fast-page-mode DRAM and brings the device out of power-up. After reset it holds the strobes idle for a fixed start-up interval, counted in system clocks. It then issues a fixed number of dummy refresh cycles on the active-low row strobe, column strobe and write enable. When those cycles finish it raises `ready`, and normal traffic can start. While ready, it can also produce the single refresh-style cycle that latches the device's special test mode, or one that clears it again.

The wait length is `ceil(CLK_KHZ * WAIT_US / 1000)` clocks, so the minimum interval is never shortened. Two kinds of dummy cycle exist, and `init_mode_cbr` selects between them. A row-only refresh drives an internal row counter on `row_addr` and keeps the column strobe high. A column-before-row refresh lowers the column strobe before the row strobe. The width of every pulse and gap comes from an input.

States: WAIT (start-up interval), LEAD (column strobe low, row strobe high), RAS (row strobe low), PRE (all strobes high, precharge), READY. Transitions:
- WAIT→LEAD or WAIT→RAS when the interval expires, depending on the kind of cycle.
- LEAD→RAS when the lead count ends.
- RAS→PRE when the row-pulse count ends.
- PRE→LEAD or PRE→RAS for the next dummy cycle of the burst.
- PRE→READY after the last cycle.
- READY→LEAD or READY→RAS on an accepted initialization or test-mode request.

Top module: `dram_init_seq`

## Requirements
- R1: From reset release, `ras_n` and `cas_n` stay high for exactly WAIT_CLKS = ceil(CLK_KHZ*WAIT_US/1000) clock edges. The first strobe goes low after edge WAIT_CLKS.
- R2: `ready` rises only after INIT_CYCLES dummy cycles have each completed, including their precharge. While `ready` is high, `ras_n`, `cas_n` and `we_n` are all high.
- R3: Every dummy cycle is a column-before-row refresh when `init_mode_cbr`=1, and a row-only refresh when `init_mode_cbr`=0.
- R4: In a column-before-row cycle, the strobes behave as follows:
  - `cas_n` is low for `t_lead` clocks while `ras_n` is high.
  - `ras_n` is then low for `t_ras` clocks.
  - `cas_n` stays low for the first min(`t_cas`,`t_ras`) of those clocks.
  - All strobes are then high for `t_pre` clocks.
- R5: In a row-only cycle, `ras_n` is low for `t_ras` clocks and then high for `t_pre` clocks, and `cas_n` stays high. `row_addr` is 0 after reset and rises by 1 after each row-only cycle.
- R6: In READY, `tm_req`=1 with `tm_enter`=1 issues a column-before-row cycle with `we_n` low from the fall of `cas_n` to the end of the row pulse. `test_mode` becomes 1 in the clock in which `ras_n` falls.
- R7: In READY, `tm_req`=1 with `tm_enter`=0 issues one refresh cycle of the kind chosen by `init_mode_cbr`. Any refresh cycle with `we_n` high clears `test_mode` in the clock in which `ras_n` falls. `test_mode` changes at no other time.
- R8: `init_req` and `tm_req` have no effect while not in READY. In READY, `init_req` reruns the INIT_CYCLES burst without the start-up wait and takes precedence over `tm_req`.
- R9: Reset returns the block to WAIT with `ready`=0, `test_mode`=0, all strobes high and `row_addr`=0.
- R10: A width input of 0 on `t_lead`, `t_ras`, `t_cas` or `t_pre` acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; restarts the whole sequence |
| init_mode_cbr | input | 1 | 1: column-before-row refresh, 0: row-only refresh |
| t_lead | input | TW | Clocks that `cas_n` leads `ras_n` in a column-before-row cycle |
| t_ras | input | TW | Row strobe low width in clocks |
| t_cas | input | TW | Column strobe low width, counted from the fall of `ras_n` |
| t_pre | input | TW | Precharge gap in clocks |
| init_req | input | 1 | Rerun the dummy-cycle burst (accepted only in READY) |
| tm_req | input | 1 | Issue one test-mode entry or exit cycle (accepted only in READY) |
| tm_enter | input | 1 | With `tm_req`: 1 enters, 0 exits test mode |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| row_addr | output | ROW_W | Row address for row-only refresh cycles |
| ready | output | 1 | Initialization done; the block is idle |
| test_mode | output | 1 | The last issued cycle was a test-mode entry |

## Verification
The assertions assume that `init_mode_cbr` and the four width inputs stay constant while a cycle is in progress. They also assume that the widths fit below the limit of their TW-bit field.

The stimulus changes these inputs only while reset is held, and it keeps them at those values until the next reset. It sweeps every combination of the small widths, including 0, in both refresh modes. Requests are driven on falling edges and held over busy stretches, so that any reaction to them while busy would show up.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [2:0] {
        S_WAIT,
        S_LEAD,
        S_RAS,
        S_PRE,
        S_READY
    } seq_state_t;

    typedef enum logic [1:0] {
        K_ROR,
        K_CBR,
        K_TM_SET
    } cyc_kind_t;

    function automatic seq_state_t entry_state(input cyc_kind_t k);
        return (k == K_ROR) ? S_RAS : S_LEAD;
    endfunction

endpackage

// File: rtl/dinit_wait_timer.sv
module dinit_wait_timer #(
    parameter int WAIT_CLKS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(WAIT_CLKS + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(WAIT_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/dinit_row_ctr.sv
module dinit_row_ctr #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= row + ROW_W'(1);
        end
    end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int CLK_KHZ     = 250000,
    parameter int WAIT_US     = 200,
    parameter int INIT_CYCLES = 8,
    parameter int ROW_W       = 12,
    parameter int TW          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_mode_cbr,
    input  logic [TW-1:0]    t_lead,
    input  logic [TW-1:0]    t_ras,
    input  logic [TW-1:0]    t_cas,
    input  logic [TW-1:0]    t_pre,
    input  logic             init_req,
    input  logic             tm_req,
    input  logic             tm_enter,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             ready,
    output logic             test_mode
);
    localparam int WAIT_CLKS = (CLK_KHZ * WAIT_US + 999) / 1000;
    localparam int IW        = $clog2(INIT_CYCLES + 1);

    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] w);
        return (w == '0) ? TW'(1) : w;
    endfunction

    seq_state_t    state, nstate;
    cyc_kind_t     kind, nkind, refresh_kind;
    logic [TW-1:0] phase;
    logic [IW-1:0] left;
    logic          in_burst;
    logic          burst_go;
    logic          ph_last;
    logic          wait_done;
    logic          row_step;
    logic          tm_q;
    logic [TW-1:0] lead_e, ras_e, cas_e, pre_e;

    assign lead_e = at_least_one(t_lead);
    assign ras_e  = at_least_one(t_ras);
    assign cas_e  = at_least_one(t_cas);
    assign pre_e  = at_least_one(t_pre);

    dinit_wait_timer #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_WAIT),
        .done  (wait_done)
    );

    assign row_step = (state == S_RAS) && ph_last && (kind == K_ROR);

    dinit_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_step),
        .row   (row_addr)
    );

    // End of the current timed phase
    always_comb begin
        unique case (state)
            S_LEAD:  ph_last = (phase == lead_e - TW'(1));
            S_RAS:   ph_last = (phase == ras_e - TW'(1));
            S_PRE:   ph_last = (phase == pre_e - TW'(1));
            default: ph_last = 1'b0;
        endcase
    end

    // Next-state and next-kind selection
    always_comb begin
        nstate       = state;
        nkind        = kind;
        burst_go     = 1'b0;
        refresh_kind = init_mode_cbr ? K_CBR : K_ROR;
        unique case (state)
            S_WAIT: begin
                if (wait_done) begin
                    burst_go = 1'b1;
                    nkind    = refresh_kind;
                    nstate   = entry_state(refresh_kind);
                end
            end
            S_LEAD: begin
                if (ph_last) nstate = S_RAS;
            end
            S_RAS: begin
                if (ph_last) nstate = S_PRE;
            end
            S_PRE: begin
                if (ph_last) begin
                    if (in_burst && (left > IW'(1))) begin
                        nkind  = refresh_kind;
                        nstate = entry_state(refresh_kind);
                    end else begin
                        nstate = S_READY;
                    end
                end
            end
            S_READY: begin
                if (init_req) begin
                    burst_go = 1'b1;
                    nkind    = refresh_kind;
                    nstate   = entry_state(refresh_kind);
                end else if (tm_req) begin
                    nkind  = tm_enter ? K_TM_SET : refresh_kind;
                    nstate = entry_state(nkind);
                end
            end
            default: nstate = S_WAIT;
        endcase
    end

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_WAIT;
            kind     <= K_ROR;
            phase    <= '0;
            left     <= '0;
            in_burst <= 1'b0;
            tm_q     <= 1'b0;
        end else begin
            state <= nstate;
            kind  <= nkind;
            if (nstate != state) begin
                phase <= '0;
            end else if (state != S_WAIT && state != S_READY) begin
                phase <= phase + TW'(1);
            end
            if (burst_go) begin
                left     <= IW'(INIT_CYCLES);
                in_burst <= 1'b1;
            end else if (state == S_PRE && ph_last) begin
                left <= left - IW'(1);
                if (nstate == S_READY) in_burst <= 1'b0;
            end
            if (nstate == S_RAS && state != S_RAS) begin
                tm_q <= (nkind == K_TM_SET);
            end
        end
    end

    // Strobe decode from state
    always_comb begin
        ras_n     = !(state == S_RAS);
        cas_n     = !((state == S_LEAD) ||
                      (state == S_RAS && kind != K_ROR && phase < cas_e));
        we_n      = !(kind == K_TM_SET && (state == S_LEAD || state == S_RAS));
        ready     = (state == S_READY);
        test_mode = tm_q;
    end
endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
    parameter int CLK_KHZ     = 250000,
    parameter int WAIT_US     = 200,
    parameter int INIT_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ready,
    input logic test_mode
);
    localparam int PROD  = CLK_KHZ * WAIT_US;
    localparam int WAITC = PROD / 1000 + ((PROD % 1000) != 0 ? 1 : 0);

    logic [31:0] since_rst;
    logic [31:0] ras_falls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            ras_falls <= '0;
        end else begin
            if (since_rst < 32'(WAITC)) since_rst <= since_rst + 32'd1;
            if ($fell(ras_n) && ras_falls < 32'(INIT_CYCLES)) ras_falls <= ras_falls + 32'd1;
        end
    end

    p_quiet_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 32'(WAITC)) |-> (ras_n && cas_n));

    p_ready_after_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (ras_falls >= 32'(INIT_CYCLES)));

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n && cas_n && we_n));

    p_cas_steady_at_ras_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (cas_n == $past(cas_n)));

    p_we_inside_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cas_n || !ras_n));

    p_tm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !we_n) |-> test_mode);

    p_tm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && we_n) |-> !test_mode);

    p_tm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ras_n) |-> $stable(test_mode));
endmodule

bind dram_init_seq dram_init_seq_chk #(
    .CLK_KHZ     (CLK_KHZ),
    .WAIT_US     (WAIT_US),
    .INIT_CYCLES (INIT_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ready     (ready),
    .test_mode (test_mode)
);

// File: tb/dram_init_seq_test.sv
`timescale 1ns/1ps
module dram_init_seq_test;
    localparam int CLK_KHZ = 1500;
    localparam int WAIT_US = 3;
    localparam int INITN   = 8;
    localparam int ROW_W   = 12;
    localparam int TW      = 4;
    // 1500 kHz * 3 us = 4.5 clocks, must round up to 5
    localparam int EXP_WAIT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_mode_cbr = 1'b0;
    logic [TW-1:0] t_lead = '0, t_ras = '0, t_cas = '0, t_pre = '0;
    logic init_req = 1'b0, tm_req = 1'b0, tm_enter = 1'b0;
    logic ras_n, cas_n, we_n, ready, test_mode;
    logic [ROW_W-1:0] row_addr;

    int checks = 0;
    int failures = 0;
    int exp_row = 0;
    int le, re, ce, pe;
    bit done_flag = 0;

    always #2 clk = ~clk;

    dram_init_seq #(
        .CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US), .INIT_CYCLES(INITN),
        .ROW_W(ROW_W), .TW(TW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .init_mode_cbr(init_mode_cbr),
        .t_lead(t_lead), .t_ras(t_ras), .t_cas(t_cas), .t_pre(t_pre),
        .init_req(init_req), .tm_req(tm_req), .tm_enter(tm_enter),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr),
        .ready(ready), .test_mode(test_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One full cycle of either kind; samples every clock of it
    task automatic expect_cycle(input bit cbr, input bit wel, input bit tb, input bit ta);
        int nl = cbr ? le : 0;
        int tot = nl + re + pe;
        string rq = cbr ? "R4" : "R5";
        for (int j = 0; j < tot; j++) begin
            @(negedge clk);
            if (j == 0) begin
                init_req = 1'b0;
                tm_req   = 1'b0;
            end
            begin
                bit in_ras = (j >= nl) && (j < nl + re);
                bit cas_lo = cbr && ((j < nl) || (in_ras && (j - nl) < ce));
                bit we_lo  = wel && (j < nl + re);
                chk(rq, "ras_n", int'(ras_n), int'(!in_ras));
                chk(cbr ? "R4" : "R3", "cas_n", int'(cas_n), int'(!cas_lo));
                chk("R6", "we_n", int'(we_n), int'(!we_lo));
                chk("R2", "ready busy", int'(ready), 0);
                chk(ta ? "R6" : "R7", "test_mode", int'(test_mode), int'((j < nl) ? tb : ta));
                if (!cbr && in_ras)
                    chk("R5", "row_addr", int'(row_addr), exp_row % (1 << ROW_W));
            end
        end
        if (!cbr) exp_row++;
    endtask

    task automatic ready_check(input bit tm);
        @(negedge clk);
        chk("R2", "ready", int'(ready), 1);
        chk("R2", "idle strobes", int'({ras_n, cas_n, we_n}), 7);
        chk("R7", "test_mode idle", int'(test_mode), int'(tm));
    endtask

    // Reset, start-up wait, burst of dummy cycles, ready
    task automatic do_init(input bit cbr, input int l, input int r, input int c, input int p);
        @(negedge clk);
        rst_n = 1'b0;
        init_mode_cbr = cbr;
        t_lead = TW'(l); t_ras = TW'(r); t_cas = TW'(c); t_pre = TW'(p);
        le = (l == 0) ? 1 : l;   // R10
        re = (r == 0) ? 1 : r;
        ce = (c == 0) ? 1 : c;
        pe = (p == 0) ? 1 : p;
        init_req = 1'b1;         // R8: held through the busy wait
        tm_req   = 1'b1;
        tm_enter = 1'b1;
        exp_row  = 0;
        @(negedge clk);
        chk("R9", "reset strobes", int'({ras_n, cas_n, we_n}), 7);
        chk("R9", "reset ready", int'(ready), 0);
        chk("R9", "reset test_mode", int'(test_mode), 0);
        chk("R9", "reset row", int'(row_addr), 0);
        rst_n = 1'b1;
        for (int k = 1; k < EXP_WAIT; k++) begin
            @(negedge clk);
            chk("R1", "wait ras_n", int'(ras_n), 1);
            chk("R1", "wait cas_n", int'(cas_n), 1);
        end
        for (int n = 0; n < INITN; n++) expect_cycle(cbr, 1'b0, 1'b0, 1'b0);
        ready_check(1'b0);
    endtask

    task automatic request_tm(input bit enter);
        tm_req   = 1'b1;
        tm_enter = enter;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Sweep of modes and widths (R1..R5, R8, R10)
        for (int m = 0; m < 2; m++)
            for (int l = 0; l < 3; l++)
                for (int r = 0; r < 4; r++)
                    for (int c = 0; c < 4; c++)
                        for (int p = 0; p < 3; p++)
                            do_init(m[0], l, r, c, p);

        // Row-only config: test-mode entry then row-only exit (R6, R7)
        do_init(1'b0, 1, 2, 1, 1);
        request_tm(1'b1);
        expect_cycle(1'b1, 1'b1, 1'b0, 1'b1);
        ready_check(1'b1);
        request_tm(1'b0);
        expect_cycle(1'b0, 1'b0, 1'b1, 1'b0);
        ready_check(1'b0);
        // Rerun from ready without wait; init_req beats tm_req (R8)
        init_req = 1'b1;
        tm_req   = 1'b1;
        tm_enter = 1'b1;
        for (int n = 0; n < INITN; n++) expect_cycle(1'b0, 1'b0, 1'b0, 1'b0);
        ready_check(1'b0);

        // Column-first config: entry, plain exit, entry, cleared by rerun (R6, R7)
        do_init(1'b1, 2, 3, 2, 1);
        request_tm(1'b1);
        expect_cycle(1'b1, 1'b1, 1'b0, 1'b1);
        ready_check(1'b1);
        request_tm(1'b0);
        expect_cycle(1'b1, 1'b0, 1'b1, 1'b0);
        ready_check(1'b0);
        request_tm(1'b1);
        expect_cycle(1'b1, 1'b1, 1'b0, 1'b1);
        ready_check(1'b1);
        init_req = 1'b1;
        expect_cycle(1'b1, 1'b0, 1'b1, 1'b0);
        for (int n = 1; n < INITN; n++) expect_cycle(1'b1, 1'b0, 1'b0, 1'b0);
        ready_check(1'b0);

        // Enter test mode, then reset clears it and restarts the wait (R9)
        request_tm(1'b1);
        expect_cycle(1'b1, 1'b1, 1'b0, 1'b1);
        ready_check(1'b1);
        do_init(1'b0, 1, 3, 1, 2);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule